// File: doc/BRIEF.md
# Auto-Incrementing Register File Slave

This block is the register-access core of a byte-addressed peripheral on a two-wire style serial bus. A byte-level front end reports a start condition with its direction, each data byte written by the host, each data byte the host consumes, and the stop condition. The core keeps a register pointer and decodes it against a map of ordinary byte registers, read-only registers, several multi-byte registers and an indirect scratch bank.

In a write transaction the first byte sets the pointer and every later byte is data. During a burst the pointer steps to the next address after each byte, except at the multi-byte registers and at the scratch bank's index and data window. At those addresses it stays put. The multi-byte registers absorb successive bytes of the burst into successive bytes of the one register. The scratch bank index moves on by one for every byte that passes through the window. Read data is presented combinationally for the current pointer and byte position, and the host's read strobe consumes it.

The control path is a four-state machine. ST_IDLE waits for a start. A write-direction start enters ST_GET_PTR, where the first written byte loads the pointer and moves to ST_WRITE. A read-direction start enters ST_READ. A start in any state restarts into ST_GET_PTR or ST_READ by direction, and a stop in any state returns to ST_IDLE. A start wins over a stop in the same cycle.

Top module: `regslv_core`

## Requirements
- R1: After reset, every writable register, every byte of the multi-byte writable registers, every scratch bank byte and the bank index read as 0x00, and the pointer is 0x00.
- R2: After a write-direction start, the first written byte becomes the register pointer and resets the byte position to 0. Each later byte in the same transaction is written as data.
- R3: At an ordinary address, each data byte read or written advances the pointer by one, wrapping from 0xFF to 0x00. Addresses 0x00 to 0x1F are read-write registers.
- R4: Addresses 0x20 to 0x27 are read-only and return 0xA0 plus their offset from 0x20. Writes to them are ignored, but the pointer still advances.
- R5: Any address not otherwise listed reads 0x00 and ignores writes, and the pointer advances past it.
- R6: At the multi-byte addresses the pointer holds, and each byte moves to the next byte of the register, returning to byte 0 after the last one. Address 0x29 is 5 bytes, 0x2D is 4 bytes and 0x4F is 2 bytes, all read-write. Address 0x7F is 8 bytes and read-only, byte k reading 0xC0 plus k.
- R7: Address 0x60 holds the pointer and reads the bank index. A write sets the index, and any value of 200 or more is clamped to 199.
- R8: Address 0x61 holds the pointer and reads or writes the bank byte at the index. Each byte moved through it advances the index by one, wrapping from 199 to 0.
- R9: Read strobes outside a read transaction, and write strobes outside a write transaction, change nothing. So do strobes after a stop.
- R10: Every start returns the multi-byte byte position to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Start or repeated start, one-cycle pulse |
| bus_rnw | input | 1 | Direction qualifying bus_start, 1 = read |
| bus_stop | input | 1 | Stop condition, one-cycle pulse |
| bus_wr | input | 1 | Host wrote a byte, one-cycle pulse |
| bus_wdata | input | 8 | Byte written by the host |
| bus_rd | input | 1 | Host consumed the presented read byte |
| bus_rdata | output | 8 | Byte at the current pointer and byte position |

## Verification
The bench builds the core with its default parameters: 32 read-write registers, eight read-only registers at 0x20 and a 200-byte bank. With these values, short bursts can cross the 0x1F to 0x20 writable/read-only boundary, run from the unlisted address 0x28 into the 5-byte register at 0x29, and wrap the pointer from 0xFF to 0x00. The index can be clamped with write values above 199 and wrapped at the 199/0 edge within a few bytes. Random bursts of one to six bytes at these addresses are mixed with directed cases for wide-register wrap, ignored strobes and repeated starts.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GET_PTR,
        ST_WRITE,
        ST_READ
    } bus_state_e;

    localparam logic [7:0] IDX_ADDR = 8'h60;
    localparam logic [7:0] WIN_ADDR = 8'h61;
    localparam int NUM_WIDE = 4;
    localparam int SUB_W    = 3;
    localparam int MAX_WIDE = 1 << SUB_W;

    function automatic logic [7:0] wide_addr(input int k);
        case (k)
            0:       return 8'h29;
            1:       return 8'h2D;
            2:       return 8'h4F;
            default: return 8'h7F;
        endcase
    endfunction

    function automatic logic [3:0] wide_len(input int k);
        case (k)
            0:       return 4'd5;
            1:       return 4'd4;
            2:       return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic wide_ro(input int k);
        return (k == 3);
    endfunction

    function automatic logic is_wide(input logic [7:0] a);
        for (int k = 0; k < NUM_WIDE; k++)
            if (a == wide_addr(k)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [SUB_W-1:0] wide_last(input logic [7:0] a);
        for (int k = 0; k < NUM_WIDE; k++)
            if (a == wide_addr(k)) return SUB_W'(wide_len(k) - 4'd1);
        return '0;
    endfunction

    function automatic logic ptr_holds(input logic [7:0] a);
        return is_wide(a) || (a == IDX_ADDR) || (a == WIN_ADDR);
    endfunction

endpackage

// File: rtl/regslv_fsm.sv
module regslv_fsm
    import regslv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic             bus_rnw,
    input  logic             bus_stop,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_rd,
    output logic [7:0]       ptr_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             wr_fire_o,
    output logic             rd_fire_o
);

    bus_state_e       state_q, state_d;
    logic [7:0]       ptr_q;
    logic [SUB_W-1:0] sub_q;
    logic             quiet;
    logic             ptr_load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_start) begin
            state_d = bus_rnw ? ST_READ : ST_GET_PTR;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_GET_PTR: if (bus_wr) state_d = ST_WRITE;
                ST_WRITE:   state_d = ST_WRITE;
                ST_READ:    state_d = ST_READ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs: byte-movement strobes
    always_comb begin
        quiet     = !bus_start && !bus_stop;
        ptr_load  = 1'b0;
        wr_fire_o = 1'b0;
        rd_fire_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_GET_PTR: ptr_load  = quiet && bus_wr;
            ST_WRITE:   wr_fire_o = quiet && bus_wr;
            ST_READ:    rd_fire_o = quiet && bus_rd;
        endcase
    end

    // pointer and multi-byte position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= 8'h00;
            sub_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= bus_wdata;
            sub_q <= '0;
        end else if (bus_start) begin
            sub_q <= '0;
        end else if (wr_fire_o || rd_fire_o) begin
            if (ptr_holds(ptr_q)) begin
                if (is_wide(ptr_q))
                    sub_q <= (sub_q == wide_last(ptr_q)) ? '0 : sub_q + 1'b1;
            end else begin
                ptr_q <= ptr_q + 8'd1;
                sub_q <= '0;
            end
        end
    end

    assign ptr_o = ptr_q;
    assign sub_o = sub_q;

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GET_PTR && bus_wr && !bus_start && !bus_stop)
        |=> (ptr_q == $past(bus_wdata) && sub_q == '0 && state_q == ST_WRITE));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_fire_o || rd_fire_o) && !ptr_holds(ptr_q))
        |=> (ptr_q == $past(ptr_q) + 8'd1));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_fire_o || rd_fire_o) && ptr_holds(ptr_q))
        |=> (ptr_q == $past(ptr_q)));

    // R6
    sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_q <= wide_last(ptr_q)));

    // R10
    sub_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (sub_q == '0));

endmodule

// File: rtl/regslv_regs.sv
module regslv_regs
    import regslv_pkg::*;
#(
    parameter int PLAIN_COUNT = 32,
    parameter int RO_BASE     = 32,
    parameter int RO_COUNT    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       ptr_i,
    input  logic [SUB_W-1:0] sub_i,
    input  logic             wr_fire_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rd_byte_o
);

    localparam int PLAIN_AW = $clog2(PLAIN_COUNT);

    logic [7:0] plain_q [PLAIN_COUNT];
    logic [7:0] wide_rd [NUM_WIDE];
    logic       in_plain;
    logic       in_ro;

    assign in_plain = int'(ptr_i) < PLAIN_COUNT;
    assign in_ro    = (int'(ptr_i) >= RO_BASE) && (int'(ptr_i) < RO_BASE + RO_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PLAIN_COUNT; i++) plain_q[i] <= 8'h00;
        end else if (wr_fire_i && in_plain) begin
            plain_q[ptr_i[PLAIN_AW-1:0]] <= wdata_i;
        end
    end

    for (genvar k = 0; k < NUM_WIDE; k++) begin : g_wide
        if (wide_ro(k)) begin : g_ro
            assign wide_rd[k] = 8'hC0 | {5'b0, sub_i};
        end else begin : g_rw
            logic [7:0] wb_q [MAX_WIDE];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < MAX_WIDE; i++) wb_q[i] <= 8'h00;
                end else if (wr_fire_i && ptr_i == wide_addr(k)) begin
                    wb_q[sub_i] <= wdata_i;
                end
            end
            assign wide_rd[k] = wb_q[sub_i];
        end
    end

    always_comb begin
        rd_byte_o = 8'h00;
        if (in_plain) begin
            rd_byte_o = plain_q[ptr_i[PLAIN_AW-1:0]];
        end else if (in_ro) begin
            rd_byte_o = 8'hA0 | 8'(int'(ptr_i) - RO_BASE);
        end else begin
            for (int k = 0; k < NUM_WIDE; k++)
                if (ptr_i == wide_addr(k)) rd_byte_o = wide_rd[k];
        end
    end

    // R4
    ro_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ro |-> (rd_byte_o[7:4] == 4'hA));

endmodule

// File: rtl/regslv_bank.sv
module regslv_bank
    import regslv_pkg::*;
#(
    parameter int DEPTH = 200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               ptr_i,
    input  logic                     wr_fire_i,
    input  logic                     rd_fire_i,
    input  logic [7:0]               wdata_i,
    output logic [$clog2(DEPTH)-1:0] idx_o,
    output logic [7:0]               win_byte_o
);

    localparam int IW = $clog2(DEPTH);

    logic [7:0]    mem_q [DEPTH];
    logic [IW-1:0] idx_q;
    logic          at_win;
    logic          at_idx;

    assign at_win = (ptr_i == WIN_ADDR);
    assign at_idx = (ptr_i == IDX_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_fire_i && at_idx) begin
            idx_q <= (int'(wdata_i) >= DEPTH) ? IW'(DEPTH - 1) : IW'(wdata_i);
        end else if ((wr_fire_i || rd_fire_i) && at_win) begin
            idx_q <= (int'(idx_q) == DEPTH - 1) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (wr_fire_i && at_win) begin
            mem_q[idx_q] <= wdata_i;
        end
    end

    assign idx_o      = idx_q;
    assign win_byte_o = mem_q[idx_q];

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_q) < DEPTH);

    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_fire_i || rd_fire_i) && at_win)
        |=> (idx_q == ((int'($past(idx_q)) == DEPTH - 1) ? '0 : $past(idx_q) + 1'b1)));

    // R7
    idx_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire_i && at_idx && int'(wdata_i) >= DEPTH) |=> (int'(idx_q) == DEPTH - 1));

endmodule

// File: rtl/regslv_core.sv
module regslv_core
    import regslv_pkg::*;
#(
    parameter int PLAIN_COUNT = 32,
    parameter int RO_BASE     = 32,
    parameter int RO_COUNT    = 8,
    parameter int BANK_DEPTH  = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_rnw,
    input  logic       bus_stop,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata
);

    localparam int IW = $clog2(BANK_DEPTH);

    logic [7:0]       ptr;
    logic [SUB_W-1:0] sub;
    logic             wr_fire;
    logic             rd_fire;
    logic [7:0]       reg_byte;
    logic [IW-1:0]    bank_idx;
    logic [7:0]       win_byte;

    regslv_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_rnw   (bus_rnw),
        .bus_stop  (bus_stop),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .ptr_o     (ptr),
        .sub_o     (sub),
        .wr_fire_o (wr_fire),
        .rd_fire_o (rd_fire)
    );

    regslv_regs #(
        .PLAIN_COUNT (PLAIN_COUNT),
        .RO_BASE     (RO_BASE),
        .RO_COUNT    (RO_COUNT)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_i     (ptr),
        .sub_i     (sub),
        .wr_fire_i (wr_fire),
        .wdata_i   (bus_wdata),
        .rd_byte_o (reg_byte)
    );

    regslv_bank #(
        .DEPTH (BANK_DEPTH)
    ) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_i      (ptr),
        .wr_fire_i  (wr_fire),
        .rd_fire_i  (rd_fire),
        .wdata_i    (bus_wdata),
        .idx_o      (bank_idx),
        .win_byte_o (win_byte)
    );

    always_comb begin
        if (ptr == IDX_ADDR)      bus_rdata = 8'(bank_idx);
        else if (ptr == WIN_ADDR) bus_rdata = win_byte;
        else                      bus_rdata = reg_byte;
    end

    // R9
    no_double_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && rd_fire));

endmodule

// File: tb/test_regslv_core.sv
module test_regslv_core;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_rnw = 1'b0, bus_stop = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model: 0 idle, 1 get pointer, 2 write, 3 read
    int       m_state = 0;
    int       m_ptr = 0, m_sub = 0, m_idx = 0;
    bit [7:0] m_plain [32];
    bit [7:0] m_wide [3][8];
    bit [7:0] m_bank [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    regslv_core i_regslv_core (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rnw(bus_rnw),
        .bus_stop(bus_stop), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic int wide_k(int a);
        case (a)
            8'h29: return 0;
            8'h2D: return 1;
            8'h4F: return 2;
            8'h7F: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int wide_n(int k);
        case (k) 0: return 5; 1: return 4; 2: return 2; default: return 8; endcase
    endfunction

    function automatic bit [7:0] exp_byte();
        int k = wide_k(m_ptr);
        if (m_ptr < 32) return m_plain[m_ptr];
        if (m_ptr >= 32 && m_ptr < 40) return 8'(8'hA0 + m_ptr - 32);
        if (k == 3) return 8'(8'hC0 + m_sub);
        if (k >= 0) return m_wide[k][m_sub];
        if (m_ptr == 8'h60) return 8'(m_idx);
        if (m_ptr == 8'h61) return m_bank[m_idx];
        return 8'h00;
    endfunction

    function automatic void advance();
        int k = wide_k(m_ptr);
        if (k >= 0) m_sub = (m_sub == wide_n(k) - 1) ? 0 : m_sub + 1;
        else if (m_ptr == 8'h61) m_idx = (m_idx == DEPTH - 1) ? 0 : m_idx + 1;
        else if (m_ptr != 8'h60) m_ptr = (m_ptr + 1) & 8'hFF;
    endfunction

    function automatic void model_write(bit [7:0] b);
        int k = wide_k(m_ptr);
        if (m_ptr < 32) m_plain[m_ptr] = b;
        else if (k >= 0 && k < 3) m_wide[k][m_sub] = b;
        else if (m_ptr == 8'h60) m_idx = (b >= DEPTH) ? DEPTH - 1 : int'(b);
        else if (m_ptr == 8'h61) m_bank[m_idx] = b;
        if (m_ptr != 8'h60) advance();
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h (ptr 0x%02h)", tag, got, exp, m_ptr);
        end
    endtask

    task automatic tx_start(bit rnw);
        bus_start = 1'b1; bus_rnw = rnw;
        @(negedge clk);
        bus_start = 1'b0;
        m_state = rnw ? 3 : 1;
        m_sub = 0;
    endtask

    task automatic tx_stop();
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        m_state = 0;
    endtask

    task automatic put(bit [7:0] b);
        bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk);
        bus_wr = 1'b0;
        if (m_state == 1) begin
            m_ptr = b; m_sub = 0; m_state = 2;
        end else if (m_state == 2) begin
            model_write(b);
        end
    endtask

    task automatic get(string tag);
        if (m_state == 3) check(tag, bus_rdata, exp_byte());
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        if (m_state == 3) advance();
    endtask

    task automatic read_at(bit [7:0] a, int n, string tag);
        tx_start(0); put(a); tx_start(1);
        for (int i = 0; i < n; i++) get(tag);
        tx_stop();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, pointer 0 on a bare read
        tx_start(1); get("R1"); tx_stop();
        read_at(8'h60, 2, "R1");
        read_at(8'h61, 1, "R1");
        read_at(8'h29, 5, "R1");
        read_at(8'h1F, 1, "R1");

        // R2 R3: pointer byte then data, auto increment on write and read
        tx_start(0); put(8'h05); put(8'h11); put(8'h22); put(8'h33); tx_stop();
        read_at(8'h05, 4, "R3");
        read_at(8'h06, 1, "R2");

        // R4: writable/read-only boundary, writes ignored, pointer advances
        tx_start(0); put(8'h1E); put(8'h5A); put(8'h6B); put(8'h77); put(8'h88); put(8'h99); tx_stop();
        read_at(8'h1E, 6, "R4");

        // R5: unlisted address then into 0x29; pointer wrap 0xFF -> 0x00
        tx_start(0); put(8'h28); put(8'hAA); put(8'h3C); tx_stop();
        read_at(8'h28, 2, "R5");
        tx_start(0); put(8'hFF); put(8'hEE); put(8'h44); tx_stop();
        read_at(8'hFF, 2, "R5");
        read_at(8'h80, 1, "R5");

        // R6: wide register wrap and read-only wide register
        tx_start(0); put(8'h29);
        for (int i = 0; i < 6; i++) put(8'(8'h10 + i));
        tx_stop();
        read_at(8'h29, 7, "R6");
        tx_start(0); put(8'h7F); put(8'h00); put(8'h01); tx_stop();
        read_at(8'h7F, 9, "R6");
        tx_start(0); put(8'h4F); put(8'hD1); put(8'hD2); put(8'hD3); tx_stop();
        read_at(8'h4F, 3, "R6");

        // R7: index clamp, pointer holds at 0x60
        tx_start(0); put(8'h60); put(8'd250); tx_stop();
        read_at(8'h60, 2, "R7");
        tx_start(0); put(8'h60); put(8'd7); put(8'd199); put(8'd200); tx_stop();
        read_at(8'h60, 1, "R7");

        // R8: window writes wrap 199 -> 0 and reads advance the index
        tx_start(0); put(8'h60); put(8'd198); tx_stop();
        tx_start(0); put(8'h61); put(8'hB1); put(8'hB2); put(8'hB3); tx_stop();
        read_at(8'h60, 1, "R8");
        tx_start(0); put(8'h60); put(8'd198); tx_stop();
        read_at(8'h61, 4, "R8");
        read_at(8'h60, 1, "R8");

        // R9: stray strobes
        tx_start(0); put(8'h03); get("R9"); put(8'h4D); tx_stop();
        put(8'hFF); get("R9");
        tx_start(1); put(8'h12); tx_stop();
        read_at(8'h03, 2, "R9");

        // R10: repeated start resets byte position
        tx_start(0); put(8'h2D); put(8'h61); put(8'h62); put(8'h63);
        tx_start(1); get("R10"); get("R10"); tx_stop();

        // random bursts
        void'($urandom(32'd2718));
        for (int t = 0; t < 400; t++) begin
            int sel = $urandom_range(0, 9);
            bit [7:0] a;
            int n = $urandom_range(1, 6);
            case (sel)
                0: a = 8'h29; 1: a = 8'h2D; 2: a = 8'h4F; 3: a = 8'h7F;
                4: a = 8'h60; 5: a = 8'h61; 6: a = 8'h1E; 7: a = 8'hFD;
                default: a = 8'($urandom_range(0, 127));
            endcase
            if ($urandom_range(0, 1) == 1) begin
                tx_start(0); put(a);
                for (int i = 0; i < n; i++) put(8'($urandom_range(0, 255)));
                tx_stop();
            end else begin
                read_at(a, n, "R3/R6/R8 random");
            end
        end

        done = 1;
        summary();
    end

endmodule